// File: doc/BRIEF.md
# Configurable Packet Transmit Framer

This block turns one radio packet into a serial bit stream for a two-level frequency-shift modulator. A packet is made of five fields sent in a fixed order: an alternating preamble, a sync word, an optional one-byte length header, the payload, and an optional 16-bit checksum. Each field goes out most significant bit first. The modulator asks for one bit on every pulse of a bit-rate enable. The framer presents the current bit together with a valid flag, and it moves on to the next bit only when the enable is high while that flag is set.

Configuration is captured on a start pulse. It consists of a preamble length code and polarity, a sync word with its bit count, a header enable, a payload byte count and a checksum enable. Payload bytes arrive over a valid/ready byte port, and a one-byte holding register lets the next byte be fetched while the current one is shifting out. The checksum is not computed inside the framer. It clears an external CRC engine at start, hands that engine the header byte and then each payload byte in order, and sends the 16-bit value the engine returns as the closing field. A busy flag covers the whole packet, and a one-cycle done pulse marks its end.

Top module: `pkt_tx_framer`

## Requirements
- R1: Fields go out in the order preamble, sync word, header (when enabled), payload, checksum (when enabled), and every field is sent most significant bit first; a bit is consumed on a clock edge where bit_en and tx_valid are both high.
- R2: A preamble code of 1 to 30 sends eight times that many preamble bits.
- R3: Preamble code 0 sends exactly one preamble bit, and code 31 sends exactly four.
- R4: Preamble bits alternate and the first one equals pre_mode, so mode 0 gives 0101... and mode 1 gives 1010...
- R5: The sync field is the low N bits of sync_word, sent from bit N-1 down to bit 0, where N is sync_bits limited to the range 8 to 32.
- R6: With hdr_en = 1, a single length byte equal to pay_len is sent before the payload. With hdr_en = 0, no header is sent. In both cases exactly pay_len payload bytes are taken and sent.
- R7: crc_init pulses once per packet on the cycle after start is accepted. After that, crc_valid presents on crc_data the header byte (when enabled) and then each payload byte in order, never in the same cycle as crc_init. With crc_en = 1, the 16 bits of crc_val are appended after the payload; with crc_en = 0, nothing is appended.
- R8: With pay_len = 0, no payload bits are sent and in_ready never rises.
- R9: A start pulse while busy is high is ignored: no new crc_init, and the packet in flight is unchanged.
- R10: done is high for exactly one cycle, on the cycle after the edge that consumes the last bit of the packet. From that cycle on, busy is low.
- R11: If the next payload byte has not arrived, tx_valid stays low until it does, and no bit is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet (used only when idle) |
| bit_en | input | 1 | Bit-rate enable from the modulator |
| pre_code | input | 5 | Preamble length code |
| pre_mode | input | 1 | Value of the first preamble bit |
| sync_word | input | 32 | Sync word, right-aligned |
| sync_bits | input | 6 | Sync word length in bits |
| hdr_en | input | 1 | Send a length byte before the payload |
| pay_len | input | 8 | Payload byte count |
| crc_en | input | 1 | Append the checksum |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Framer takes the payload byte |
| tx_bit | output | 1 | Current bit on air |
| tx_valid | output | 1 | tx_bit is meaningful |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| crc_init | output | 1 | Clear the external CRC engine |
| crc_valid | output | 1 | crc_data is to be absorbed |
| crc_data | output | 8 | Byte for the CRC engine |
| crc_val | input | 16 | Checksum returned by the engine |

## Verification
The bench builds the framer with its default parameters: a 32-bit shift register, a 16-bit checksum, an 8-bit length and a 30-byte preamble limit. These values bring within reach the longest preamble of 240 bits, the full 32-bit sync word, a sync count above 32 that must be limited, and a 255-byte payload whose byte counters run all the way down from their maximum. The bench's CRC engine uses polynomial 0x8005 with initial value 0xFFFF. Combined with a bit enable that can fire on every cycle and a payload source that can be slow, this exposes both the stall path and the one-cycle reload bubble between payload bytes.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_HDR,
        ST_PAY,
        ST_CRC
    } tx_state_t;
endpackage

// File: rtl/pkt_tx_cfg_decode.sv
module pkt_tx_cfg_decode #(
    parameter int SW = 32,
    parameter int NW = 6,
    parameter int CW = 8
) (
    input  logic [4:0]    pre_code,
    input  logic [SW-1:0] sync_word,
    input  logic [NW-1:0] sync_bits,
    output logic [CW-1:0] pre_n,
    output logic [SW-1:0] sync_al,
    output logic [CW-1:0] sync_n
);
    localparam int SYNC_MIN = 8;

    int n_c;

    always_comb begin
        // special short preambles, else whole bytes
        if (pre_code == 5'd0)
            pre_n = CW'(1);
        else if (pre_code == 5'd31)
            pre_n = CW'(4);
        else
            pre_n = CW'({pre_code, 3'b000});

        if (int'(sync_bits) < SYNC_MIN)
            n_c = SYNC_MIN;
        else if (int'(sync_bits) > SW)
            n_c = SW;
        else
            n_c = int'(sync_bits);

        sync_n  = CW'(n_c);
        sync_al = sync_word << (SW - n_c);
    end
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import pkt_tx_pkg::*;
#(
    parameter int SW            = 32,
    parameter int CRC_W         = 16,
    parameter int LEN_W         = 8,
    parameter int MAX_PRE_BYTES = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_en,
    input  logic [4:0]       pre_code,
    input  logic             pre_mode,
    input  logic [SW-1:0]    sync_word,
    input  logic [$clog2(SW+1)-1:0] sync_bits,
    input  logic             hdr_en,
    input  logic [LEN_W-1:0] pay_len,
    input  logic             crc_en,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             tx_bit,
    output logic             tx_valid,
    output logic             busy,
    output logic             done,
    output logic             crc_init,
    output logic             crc_valid,
    output logic [7:0]       crc_data,
    input  logic [CRC_W-1:0] crc_val
);
    localparam int BW      = 8;
    localparam int NW      = $clog2(SW + 1);
    localparam int PRE_MAX = MAX_PRE_BYTES * BW;
    localparam int BIG1    = (PRE_MAX > SW) ? PRE_MAX : SW;
    localparam int BIG     = (BIG1 > CRC_W) ? BIG1 : CRC_W;
    localparam int CW      = $clog2(BIG + 1);

    typedef struct packed {
        tx_state_t        st;
        logic [SW-1:0]    sh;
        logic [CW-1:0]    cnt;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] fetch;
        logic [LEN_W-1:0] plen;
        logic [BW-1:0]    hold;
        logic             hold_full;
        logic             hdr;
        logic             crc_on;
        logic             done;
        logic             c_init;
        logic             c_vld;
        logic [BW-1:0]    c_data;
        logic [SW-1:0]    sync_sh;
        logic [CW-1:0]    sync_n;
    } regs_t;

    regs_t q, d;

    logic [CW-1:0] dec_pre_n;
    logic [SW-1:0] dec_sync_al;
    logic [CW-1:0] dec_sync_n;
    logic          accept;

    pkt_tx_cfg_decode #(.SW(SW), .NW(NW), .CW(CW)) u_dec (
        .pre_code  (pre_code),
        .sync_word (sync_word),
        .sync_bits (sync_bits),
        .pre_n     (dec_pre_n),
        .sync_al   (dec_sync_al),
        .sync_n    (dec_sync_n)
    );

    // closing field: checksum or end of packet
    function automatic regs_t f_tail(input regs_t r, input logic [CRC_W-1:0] cv);
        regs_t n = r;
        if (r.crc_on) begin
            n.st  = ST_CRC;
            n.sh  = SW'(cv) << (SW - CRC_W);
            n.cnt = CW'(CRC_W);
        end else begin
            n.st   = ST_IDLE;
            n.done = 1'b1;
            n.cnt  = '0;
        end
        return n;
    endfunction

    function automatic regs_t f_pay(input regs_t r, input logic [CRC_W-1:0] cv);
        regs_t n = r;
        if (r.plen == '0) begin
            n = f_tail(r, cv);
        end else begin
            n.st  = ST_PAY;
            n.cnt = '0;
        end
        return n;
    endfunction

    assign in_ready = ((q.st == ST_HDR) || (q.st == ST_PAY)) && !q.hold_full && (q.fetch != '0);
    assign accept   = in_valid && in_ready;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.c_init = 1'b0;
        d.c_vld  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st        = ST_PRE;
                    d.sh        = '0;
                    d.sh[SW-1]  = pre_mode;
                    d.cnt       = dec_pre_n;
                    d.sync_sh   = dec_sync_al;
                    d.sync_n    = dec_sync_n;
                    d.hdr       = hdr_en;
                    d.crc_on    = crc_en;
                    d.plen      = pay_len;
                    d.left      = pay_len;
                    d.fetch     = pay_len;
                    d.hold_full = 1'b0;
                    d.c_init    = 1'b1;
                end
            end
            ST_PRE: begin
                if (bit_en) begin
                    if (q.cnt == CW'(1)) begin
                        d.st  = ST_SYNC;
                        d.sh  = q.sync_sh;
                        d.cnt = q.sync_n;
                    end else begin
                        d.sh[SW-1] = ~q.sh[SW-1];
                        d.cnt      = q.cnt - 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (bit_en) begin
                    if (q.cnt == CW'(1)) begin
                        if (q.hdr) begin
                            d.st     = ST_HDR;
                            d.sh     = SW'(q.plen) << (SW - LEN_W);
                            d.cnt    = CW'(LEN_W);
                            d.c_vld  = 1'b1;
                            d.c_data = BW'(q.plen);
                        end else begin
                            d = f_pay(d, crc_val);
                        end
                    end else begin
                        d.sh  = q.sh << 1;
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (bit_en) begin
                    if (q.cnt == CW'(1)) begin
                        d = f_pay(d, crc_val);
                    end else begin
                        d.sh  = q.sh << 1;
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (q.cnt == '0) begin
                    // waiting for a byte: load it once the holding register has one
                    if (q.hold_full) begin
                        d.sh        = SW'(q.hold) << (SW - BW);
                        d.cnt       = CW'(BW);
                        d.hold_full = 1'b0;
                        d.left      = q.left - 1'b1;
                    end
                end else if (bit_en) begin
                    if (q.cnt == CW'(1)) begin
                        if (q.left == '0)
                            d = f_tail(d, crc_val);
                        else
                            d.cnt = '0;
                    end else begin
                        d.sh  = q.sh << 1;
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (bit_en) begin
                    if (q.cnt == CW'(1)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.cnt  = '0;
                    end else begin
                        d.sh  = q.sh << 1;
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (accept) begin
            d.hold      = in_data;
            d.hold_full = 1'b1;
            d.fetch     = q.fetch - 1'b1;
            d.c_vld     = 1'b1;
            d.c_data    = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tx_bit    = q.sh[SW-1];
    assign tx_valid  = (q.st == ST_PRE) || (q.st == ST_SYNC) || (q.st == ST_HDR) ||
                       (q.st == ST_CRC) || ((q.st == ST_PAY) && (q.cnt != '0));
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign crc_init  = q.c_init;
    assign crc_valid = q.c_vld;
    assign crc_data  = q.c_data;

    // R10: the end-of-packet pulse lasts a single cycle and the block is idle then
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: clear and absorb never coincide
    p_crc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_init && crc_valid));
    // R9: a start during a packet never restarts the engine
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !crc_init);
    // R4: inside the preamble every consumed bit is followed by its complement
    p_pre_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PRE && bit_en && q.cnt != CW'(1)) |=> (tx_bit != $past(tx_bit)));
    // R11: no bit is offered while the payload byte is missing
    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAY && q.cnt == '0) |-> !tx_valid);
    // R8: nothing is fetched beyond the byte count
    p_no_overfetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fetch == '0) |-> !in_ready);
endmodule

// File: tb/pkt_tx_framer_tb.sv
module pkt_tx_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bit_en = 1'b0;
    logic [4:0]  pre_code = '0;
    logic        pre_mode = 1'b0;
    logic [31:0] sync_word = '0;
    logic [5:0]  sync_bits = 6'd32;
    logic        hdr_en = 1'b0;
    logic [7:0]  pay_len = '0;
    logic        crc_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, tx_bit, tx_valid, busy, done;
    logic        crc_init, crc_valid;
    logic [7:0]  crc_data;
    logic [15:0] crc_val;

    always #4 clk = ~clk;

    pkt_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
        .pre_code(pre_code), .pre_mode(pre_mode), .sync_word(sync_word),
        .sync_bits(sync_bits), .hdr_en(hdr_en), .pay_len(pay_len), .crc_en(crc_en),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .busy(busy), .done(done),
        .crc_init(crc_init), .crc_valid(crc_valid), .crc_data(crc_data),
        .crc_val(crc_val)
    );

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        logic [7:0]  x = b;
        for (int i = 0; i < 8; i++) begin
            if (r[15] ^ x[7]) r = (r << 1) ^ 16'h8005;
            else              r = r << 1;
            x = x << 1;
        end
        return r;
    endfunction

    // external CRC engine: polynomial 0x8005, initial value 0xFFFF
    logic [15:0] eng_q;
    always_ff @(posedge clk) begin
        if (crc_init)       eng_q <= 16'hFFFF;
        else if (crc_valid) eng_q <= crc_step(eng_q, crc_data);
    end
    assign crc_val = eng_q;

    int   checks = 0;
    int   fails  = 0;
    bit   got[$];
    bit   expq[$];
    logic [7:0] feed[$];
    logic [7:0] feed_exp[$];
    logic [7:0] pay [0:255];
    bit   active = 0;
    int   pay_idx = 0;
    int   cur_len = 0;
    int   bit_div = 1;
    int   offer_div = 1;
    bit   rdy_prev = 0;
    bit   rdy_seen = 0;
    int   init_cnt = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // stimulus and collection, all at the falling edge
    always @(negedge clk) begin
        if (active) begin
            if (crc_valid) feed.push_back(crc_data);
            if (crc_init)  init_cnt++;
            if (in_valid && rdy_prev) begin
                pay_idx++;
                in_valid = 1'b0;
            end
            if (!in_valid && pay_idx < cur_len && ($urandom % offer_div) == 0) begin
                in_valid = 1'b1;
                in_data  = pay[pay_idx];
            end
            rdy_prev = in_ready;
            if (in_ready) rdy_seen = 1;
            bit_en = (($urandom % bit_div) == 0);
            if (bit_en && tx_valid) got.push_back(tx_bit);
        end else begin
            bit_en   = 1'b0;
            in_valid = 1'b0;
            rdy_prev = 0;
        end
    end

    task automatic build_exp();
        int np, ns;
        logic [15:0] c;
        expq.delete();
        feed_exp.delete();
        np = (pre_code == 0) ? 1 : (pre_code == 31) ? 4 : 8 * int'(pre_code);
        for (int i = 0; i < np; i++) expq.push_back(pre_mode ^ i[0]);
        ns = (sync_bits < 8) ? 8 : (sync_bits > 32) ? 32 : int'(sync_bits);
        for (int i = ns - 1; i >= 0; i--) expq.push_back(sync_word[i]);
        if (hdr_en) feed_exp.push_back(pay_len);
        for (int i = 0; i < int'(pay_len); i++) feed_exp.push_back(pay[i]);
        c = 16'hFFFF;
        foreach (feed_exp[k]) begin
            c = crc_step(c, feed_exp[k]);
            for (int i = 7; i >= 0; i--) expq.push_back(feed_exp[k][i]);
        end
        if (crc_en) for (int i = 15; i >= 0; i--) expq.push_back(c[i]);
    endtask

    task automatic run_pkt(input string tag, input bit mid_start);
        int cyc;
        int mism;
        bit seen;
        for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
        build_exp();
        got.delete();
        feed.delete();
        pay_idx  = 0;
        cur_len  = int'(pay_len);
        rdy_seen = 0;
        init_cnt = 0;
        @(negedge clk);
        active = 1;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        cyc  = 0;
        seen = 0;
        while (cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (mid_start) start = (cyc == 30);
            if (done) begin seen = 1; break; end
        end
        start = 1'b0;
        check(seen, {tag, " R10 done seen"}, int'(seen), 1);
        @(negedge clk);
        check(!done && !busy, {tag, " R10 single pulse, idle"}, int'({done, busy}), 0);
        active = 0;
        check(got.size() == expq.size(), {tag, " R1 bit count"}, got.size(), expq.size());
        mism = -1;
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            if (got[i] != expq[i] && mism < 0) mism = i;
        check(mism < 0, {tag, " R1 first mismatching bit index"}, mism, -1);
        mism = (feed.size() == feed_exp.size()) ? -1 : -2;
        for (int i = 0; i < feed.size() && i < feed_exp.size(); i++)
            if (feed[i] != feed_exp[i] && mism == -1) mism = i;
        check(mism == -1, {tag, " R7 crc feed order"}, mism, -1);
        check(pay_idx == cur_len, {tag, " R6 bytes taken"}, pay_idx, cur_len);
        check(init_cnt == 1, {tag, " R7 R9 crc_init count"}, init_cnt, 1);
        if (cur_len == 0) check(!rdy_seen, {tag, " R8 in_ready quiet"}, int'(rdy_seen), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !done && !in_ready && !tx_valid && !crc_valid && !crc_init,
              "reset state",
              int'({busy, done, in_ready, tx_valid, crc_valid, crc_init}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R5: one-bit preamble, 8-bit sync, no header, no checksum
        pre_code = 0; pre_mode = 0; sync_word = 32'h1234_56A5; sync_bits = 8;
        hdr_en = 0; crc_en = 0; pay_len = 3; bit_div = 2; offer_div = 1;
        run_pkt("R3 code0", 0);
        // R3 R4 R6 R7: four-bit preamble mode 1, 32-bit sync, header and checksum
        pre_code = 31; pre_mode = 1; sync_word = 32'h930B_51DE; sync_bits = 32;
        hdr_en = 1; crc_en = 1; pay_len = 5; bit_div = 3;
        run_pkt("R3 R4 code31", 0);
        // R2 R5: longest preamble, sync count above range limited to 32
        pre_code = 30; pre_mode = 0; sync_word = 32'hC0FF_EE11; sync_bits = 40;
        hdr_en = 0; crc_en = 1; pay_len = 2; bit_div = 1;
        run_pkt("R2 R5 code30 clamp-high", 0);
        // R5: sync count below range raised to 8
        pre_code = 2; pre_mode = 1; sync_word = 32'hFFFF_FF3C; sync_bits = 3;
        hdr_en = 1; crc_en = 0; pay_len = 1; bit_div = 2;
        run_pkt("R5 clamp-low", 0);
        // R8: empty payload with header and checksum
        pre_code = 1; pay_len = 0; hdr_en = 1; crc_en = 1; sync_bits = 16;
        run_pkt("R8 empty", 0);
        // R9: start pulsed mid-packet
        pre_code = 4; pay_len = 6; hdr_en = 1; crc_en = 1; bit_div = 2;
        run_pkt("R9 restart ignored", 1);
        // R6 R11: full-size payload, bit enable every cycle, slow source
        pre_code = 1; pay_len = 255; hdr_en = 1; crc_en = 1; sync_bits = 24;
        bit_div = 1; offer_div = 9;
        run_pkt("R6 R11 len255 stall", 0);

        // R1 R2 R4 R6 R7 R11: random packets
        for (int k = 0; k < 22; k++) begin
            case ($urandom % 6)
                0: pre_code = 0;
                1: pre_code = 31;
                default: pre_code = 5'(1 + ($urandom % 30));
            endcase
            pre_mode  = 1'($urandom);
            sync_word = $urandom;
            sync_bits = 6'(8 + ($urandom % 25));
            hdr_en    = 1'($urandom);
            crc_en    = 1'($urandom);
            pay_len   = 8'($urandom % 41);
            bit_div   = 1 + ($urandom % 4);
            offer_div = 1 + ($urandom % 6);
            run_pkt("R1 random", 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule